// File: doc/BRIEF.md
# Serial Dual-Wiper Register Controller

This block is the slave side of a two-wire serial link that sets the wiper positions of two digital potentiometers. A bit-level receiver in front of it has already recovered the line events, so it sees only a START flag, a STOP flag, and a strobe with one data bit per bit slot. The block returns an acknowledge level for the ninth slot of each byte, and during reads it returns a data bit for each slot. It holds one wiper counter register (WCR) and four data registers for each pot.

A transaction starts with an address byte. The upper nibble of that byte is the fixed device-type code 0101. The lower nibble must equal the four address pins. The instruction byte follows. Register-transfer instructions end after the instruction byte. Host read and host write instructions take a third byte. Any write to a data register is treated as nonvolatile. After the STOP that ends such a command, a busy interval of `NV_CYCLES` clocks begins. During this interval the block does not acknowledge its own address, so the host polls with START plus the address byte until it gets an acknowledge. Each wiper output follows its WCR after a short settling delay.

The controller is a Moore state machine with these states:

- `S_IDLE`: waiting for a START.
- `S_ADDR`: shifting in the address byte. It moves to `S_ADDR_ACK` on a match when not busy, and to `S_IGNORE` otherwise.
- `S_ADDR_ACK`: acknowledge slot. It moves to `S_INSTR`.
- `S_INSTR`: shifting in the instruction byte. It moves to `S_INSTR_ACK` for a known opcode and to `S_IGNORE` otherwise.
- `S_INSTR_ACK`: acknowledge slot. It moves to `S_WDATA` for host writes, to `S_RDATA` for host reads, and to `S_IGNORE` after a transfer, which runs on this slot.
- `S_WDATA`: shifting in the data byte. It moves to `S_WDATA_ACK`.
- `S_WDATA_ACK`: acknowledge slot, where the write takes place. It moves to `S_IGNORE`.
- `S_RDATA`: shifting the read byte out. It moves to `S_RDATA_ACK`.
- `S_RDATA_ACK`: the host's acknowledge slot. It moves to `S_IGNORE`.
- `S_IGNORE`: waiting for the next START or STOP.

A START in any state moves the machine to `S_ADDR`, and a STOP in any state moves it to `S_IDLE`.

Top module: `dpot_serial_ctrl`

## Requirements
- R1: After reset, every WCR, every data register and both wiper outputs read 0, `busy_o` is 0 and no acknowledge is driven.
- R2: The address byte is acknowledged only when bits [7:4] = 0101 and bits [3:0] equal `dev_addr`. On a mismatch, no slot of the transaction is acknowledged and no register changes.
- R3: During the busy interval a matching address byte gets no acknowledge. Once `busy_o` falls, the same START plus address byte is acknowledged.
- R4: Instruction byte layout is opcode [7:4], register index [3:2], bit 1 fixed zero, and pot select [0]. An opcode outside {0x1, 0x8, 0x9, 0xA, 0xB, 0xC, 0xD, 0xE} is not acknowledged, and the rest of the transaction, including any data byte, has no effect.
- R5: Opcode 0xA writes the low 6 bits of the third byte into the selected pot's WCR. All three bytes are acknowledged, and the following STOP starts no busy interval.
- R6: Opcode 0x9 returns the selected pot's WCR in the third byte, MSB first, as two zero bits followed by the 6-bit value. It is sampled once per strobe, with `rd_en_o` high for those 8 slots.
- R7: Opcode 0xC writes the low 6 bits of the third byte into the selected data register, and opcode 0xB reads it back in the R6 format. The STOP after a 0xC write raises `busy_o` for exactly `NV_CYCLES` clocks.
- R8: Opcode 0xD copies the selected data register into the selected pot's WCR only. The other pot is unchanged, and no busy interval follows.
- R9: Opcode 0xE copies the selected pot's WCR into its selected data register, and the STOP that follows starts the busy interval.
- R10: Opcode 0x1 copies data register [3:2] of each pot into that pot's WCR, on both pots at once.
- R11: Opcode 0x8 copies each pot's WCR into its own data register [3:2], on both pots at once, and the STOP that follows starts the busy interval.
- R12: A wiper output keeps its old value for at least `SETTLE_CYC` clocks after its WCR changes. It then takes the new WCR value within `SETTLE_CYC`+2 clocks and changes to no other value.
- R13: A START at any point restarts the address phase. After a STOP, data bits are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe per bit slot |
| bit_val | input | 1 | Data bit for the strobed slot |
| start_det | input | 1 | START condition seen |
| stop_det | input | 1 | STOP condition seen |
| dev_addr | input | 4 | Hardware address pins |
| ack_o | output | 1 | Acknowledge for the current ninth slot |
| rd_en_o | output | 1 | Block drives read data in this slot |
| rd_bit_o | output | 1 | Read data bit for this slot |
| busy_o | output | 1 | Nonvolatile write interval in progress |
| wiper_o | output | 12 | Settled wiper positions, pot 1 in the upper 6 bits |

## Verification
A wrong state or a wrong bit count shows up at the next ninth slot as a missing or unexpected acknowledge. That is at most nine strobes after the fault. A wrongly decoded register index or pot select stays hidden in the register file until a later read returns the wrong byte, so each transfer is followed by reads of both pots. A fault in the busy interval shows up when polling: an acknowledge comes too early, or `busy_o` stays high for a count other than `NV_CYCLES`. A settling fault shows up on `wiper_o` within `SETTLE_CYC`+2 clocks of the write.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int BYTE_W    = 8;
    localparam int POT_SEL_W = 1;
    localparam int REG_SEL_W = 2;
    localparam int NPOT      = 1 << POT_SEL_W;
    localparam int NREG      = 1 << REG_SEL_W;

    localparam logic [3:0] DEV_TYPE   = 4'b0101;
    localparam logic [3:0] OP_RD_WCR  = 4'h9;
    localparam logic [3:0] OP_WR_WCR  = 4'hA;
    localparam logic [3:0] OP_RD_DR   = 4'hB;
    localparam logic [3:0] OP_WR_DR   = 4'hC;
    localparam logic [3:0] OP_DR2WCR  = 4'hD;
    localparam logic [3:0] OP_WCR2DR  = 4'hE;
    localparam logic [3:0] OP_GDR2WCR = 4'h1;
    localparam logic [3:0] OP_GWCR2DR = 4'h8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_INSTR,
        S_INSTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RDATA_ACK,
        S_IGNORE
    } dpot_state_e;

    function automatic logic op_known(input logic [3:0] op);
        return op inside {OP_RD_WCR, OP_WR_WCR, OP_RD_DR, OP_WR_DR,
                          OP_DR2WCR, OP_WCR2DR, OP_GDR2WCR, OP_GWCR2DR};
    endfunction
endpackage

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
    parameter int NV_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);
    localparam int CNT_W = $clog2(NV_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (launch) begin
            cnt_q <= CNT_W'(NV_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/dpot_wiper_settle.sv
module dpot_wiper_settle #(
    parameter int DATA_W     = 6,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] target,
    output logic [DATA_W-1:0] wiper
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [DATA_W-1:0] tgt_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= '0;
            cnt_q <= '0;
            wiper <= '0;
        end else if (target != tgt_q) begin
            tgt_q <= target;
            cnt_q <= CNT_W'(SETTLE_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                wiper <= tgt_q;
            end
        end
    end
endmodule

// File: rtl/dpot_serial_ctrl.sv
module dpot_serial_ctrl
    import dpot_pkg::*;
#(
    parameter int DATA_W     = 6,
    parameter int NV_CYCLES  = 2000,
    parameter int SETTLE_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_stb,
    input  logic                     bit_val,
    input  logic                     start_det,
    input  logic                     stop_det,
    input  logic [3:0]               dev_addr,
    output logic                     ack_o,
    output logic                     rd_en_o,
    output logic                     rd_bit_o,
    output logic                     busy_o,
    output logic [NPOT*DATA_W-1:0]   wiper_o
);
    localparam int PAD_W = BYTE_W - DATA_W;

    dpot_state_e            state_q, state_d;
    logic [2:0]             bit_cnt_q;
    logic [BYTE_W-1:0]      shreg_q;
    logic [BYTE_W-1:0]      byte_in;
    logic [3:0]             op_q;
    logic [REG_SEL_W-1:0]   reg_q;
    logic [POT_SEL_W-1:0]   pot_q;
    logic                   nv_pend_q;
    logic                   last_bit;
    logic                   addr_hit;
    logic                   shifting;
    logic [DATA_W-1:0]      rd_val;
    logic [DATA_W-1:0]      wcr_q [NPOT];
    logic [DATA_W-1:0]      dr_q  [NPOT][NREG];
    logic [NPOT*DATA_W-1:0] wcr_flat;

    assign byte_in  = {shreg_q[BYTE_W-2:0], bit_val};
    assign last_bit = (bit_cnt_q == 3'd7);
    assign addr_hit = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:0] == dev_addr) && !busy_o;
    assign shifting = (state_q == S_ADDR) || (state_q == S_INSTR) ||
                      (state_q == S_WDATA) || (state_q == S_RDATA);
    assign rd_val   = (op_q == OP_RD_DR) ? dr_q[pot_q][reg_q] : wcr_q[pot_q];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = S_ADDR;
        end else if (stop_det) begin
            state_d = S_IDLE;
        end else if (bit_stb) begin
            unique case (state_q)
                S_IDLE:      state_d = S_IDLE;
                S_ADDR:      if (last_bit) state_d = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK:  state_d = S_INSTR;
                S_INSTR:     if (last_bit) state_d = op_known(byte_in[7:4]) ? S_INSTR_ACK : S_IGNORE;
                S_INSTR_ACK: begin
                    if (op_q == OP_WR_WCR || op_q == OP_WR_DR) begin
                        state_d = S_WDATA;
                    end else if (op_q == OP_RD_WCR || op_q == OP_RD_DR) begin
                        state_d = S_RDATA;
                    end else begin
                        state_d = S_IGNORE;
                    end
                end
                S_WDATA:     if (last_bit) state_d = S_WDATA_ACK;
                S_WDATA_ACK: state_d = S_IGNORE;
                S_RDATA:     if (last_bit) state_d = S_RDATA_ACK;
                S_RDATA_ACK: state_d = S_IGNORE;
                S_IGNORE:    state_d = S_IGNORE;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ack_o    = (state_q == S_ADDR_ACK) || (state_q == S_INSTR_ACK) ||
                   (state_q == S_WDATA_ACK);
        rd_en_o  = (state_q == S_RDATA);
        rd_bit_o = rd_en_o & shreg_q[BYTE_W-1];
    end

    // Datapath and register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            op_q      <= '0;
            reg_q     <= '0;
            pot_q     <= '0;
            nv_pend_q <= 1'b0;
            for (int p = 0; p < NPOT; p++) begin
                wcr_q[p] <= '0;
                for (int r = 0; r < NREG; r++) begin
                    dr_q[p][r] <= '0;
                end
            end
        end else if (start_det) begin
            bit_cnt_q <= '0;
        end else if (stop_det) begin
            nv_pend_q <= 1'b0;
        end else if (bit_stb) begin
            if (shifting) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            unique case (state_q)
                S_ADDR, S_WDATA: shreg_q <= byte_in;
                S_INSTR: begin
                    shreg_q <= byte_in;
                    if (last_bit) begin
                        op_q  <= byte_in[7:4];
                        reg_q <= byte_in[3:2];
                        pot_q <= byte_in[0];
                    end
                end
                S_RDATA: shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                S_INSTR_ACK: begin
                    shreg_q <= {{PAD_W{1'b0}}, rd_val};
                    if (op_q == OP_DR2WCR) begin
                        wcr_q[pot_q] <= dr_q[pot_q][reg_q];
                    end else if (op_q == OP_WCR2DR) begin
                        dr_q[pot_q][reg_q] <= wcr_q[pot_q];
                        nv_pend_q <= 1'b1;
                    end else if (op_q == OP_GDR2WCR) begin
                        for (int p = 0; p < NPOT; p++) begin
                            wcr_q[p] <= dr_q[p][reg_q];
                        end
                    end else if (op_q == OP_GWCR2DR) begin
                        for (int p = 0; p < NPOT; p++) begin
                            dr_q[p][reg_q] <= wcr_q[p];
                        end
                        nv_pend_q <= 1'b1;
                    end
                end
                S_WDATA_ACK: begin
                    if (op_q == OP_WR_WCR) begin
                        wcr_q[pot_q] <= shreg_q[DATA_W-1:0];
                    end else begin
                        dr_q[pot_q][reg_q] <= shreg_q[DATA_W-1:0];
                        nv_pend_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    dpot_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_nv (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (stop_det & nv_pend_q),
        .busy   (busy_o)
    );

    for (genvar gp = 0; gp < NPOT; gp++) begin : g_pot
        assign wcr_flat[gp*DATA_W +: DATA_W] = wcr_q[gp];
        dpot_wiper_settle #(.DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)) u_settle (
            .clk    (clk),
            .rst_n  (rst_n),
            .target (wcr_q[gp]),
            .wiper  (wiper_o[gp*DATA_W +: DATA_W])
        );
    end
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk
    import dpot_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   ack_o,
    input logic                   rd_en_o,
    input logic                   busy_o,
    input logic [NPOT*DATA_W-1:0] wiper_o,
    input logic [NPOT*DATA_W-1:0] wcr_flat,
    input dpot_state_e            state
);
    a_r3_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_det));

    a_r3_no_addr_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR_ACK) |-> !busy_o);

    a_r6_read_not_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_o, rd_en_o}));

    a_r13_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR && !ack_o && !rd_en_o));

    a_r12_wiper_from_wcr: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o != $past(wiper_o)) |-> (wiper_o == $past(wcr_flat)));
endmodule

bind dpot_serial_ctrl dpot_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .ack_o     (ack_o),
    .rd_en_o   (rd_en_o),
    .busy_o    (busy_o),
    .wiper_o   (wiper_o),
    .wcr_flat  (wcr_flat),
    .state     (state_q)
);

// File: tb/sim_dpot_serial_ctrl.sv
module sim_dpot_serial_ctrl;
    localparam int CLK_P  = 10;
    localparam int DW     = 6;
    localparam int NV     = 50;
    localparam int SET    = 4;
    localparam logic [3:0] MY_ADDR = 4'hA;
    localparam logic [7:0] ADDR_BYTE = {4'b0101, MY_ADDR};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, bit_val = 1'b0, start_det = 1'b0, stop_det = 1'b0;
    logic [3:0] dev_addr = MY_ADDR;
    logic ack_o, rd_en_o, rd_bit_o, busy_o;
    logic [2*DW-1:0] wiper_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    dpot_serial_ctrl #(.DATA_W(DW), .NV_CYCLES(NV), .SETTLE_CYC(SET)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .start_det(start_det), .stop_det(stop_det), .dev_addr(dev_addr),
        .ack_o(ack_o), .rd_en_o(rd_en_o), .rd_bit_o(rd_bit_o),
        .busy_o(busy_o), .wiper_o(wiper_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) begin bit_stb = 1'b1; bit_val = b; end
        @(negedge clk) bit_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ack = ack_o;
        send_bit(1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] d, output int en_cnt);
        d = '0;
        en_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            d = {d[6:0], rd_bit_o};
            en_cnt += int'(rd_en_o);
            send_bit(1'b0);
        end
        send_bit(1'b1);
    endtask

    function automatic logic [7:0] ins(input logic [3:0] op, input int r, input int p);
        return {op, 2'(r), 1'b0, 1'(p)};
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 4 * NV && busy_o; i++) @(negedge clk);
    endtask

    // Write transaction; returns three acks and busy right after STOP
    task automatic wr3(input logic [3:0] op, input int r, input int p, input logic [7:0] d,
                       output logic [2:0] acks, output logic bsy);
        do_start();
        send_byte(ADDR_BYTE, acks[2]);
        send_byte(ins(op, r, p), acks[1]);
        send_byte(d, acks[0]);
        do_stop();
        bsy = busy_o;
    endtask

    task automatic xfer2(input logic [3:0] op, input int r, input int p,
                         output logic [1:0] acks, output logic bsy);
        do_start();
        send_byte(ADDR_BYTE, acks[1]);
        send_byte(ins(op, r, p), acks[0]);
        do_stop();
        bsy = busy_o;
    endtask

    task automatic rd3(input logic [3:0] op, input int r, input int p, output logic [7:0] d);
        logic a1, a2;
        int en;
        do_start();
        send_byte(ADDR_BYTE, a1);
        send_byte(ins(op, r, p), a2);
        recv_byte(d, en);
        do_stop();
        if (!(a1 && a2 && en == 8)) d = 8'hEE;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 ack", int'(ack_o), 0);
        check("R1 busy", int'(busy_o), 0);
        check("R1 wiper", int'(wiper_o), 0);
        rd3(4'h9, 0, 1, d); check("R1 wcr1", d, 0);
        rd3(4'hB, 3, 0, d); check("R1 dr0_3", d, 0);
    endtask

    task automatic t_address();
        logic [2:0] a; logic b; logic [7:0] d; logic ak;
        dev_addr = 4'h5;
        wr3(4'hA, 0, 0, 8'h15, a, b);
        check("R2 wrong pins no ack", a, 3'b000);
        dev_addr = MY_ADDR;
        rd3(4'h9, 0, 0, d); check("R2 wcr unchanged", d, 0);
        do_start(); send_byte({4'b0110, MY_ADDR}, ak); do_stop();
        check("R2 wrong type code", ak, 0);
        do_start(); send_byte(ADDR_BYTE, ak); do_stop();
        check("R2 match acked", ak, 1);
    endtask

    task automatic t_wcr();
        logic [2:0] a; logic b; logic [7:0] d;
        wr3(4'hA, 0, 1, 8'h2B, a, b);
        check("R5 acks", a, 3'b111);
        check("R5 no busy", b, 0);
        rd3(4'h9, 0, 1, d); check("R6 read wcr1", d, 8'h2B);
        wr3(4'hA, 0, 1, 8'hFF, a, b);
        rd3(4'h9, 0, 1, d); check("R6 pad zeros", d, 8'h3F);
        rd3(4'h9, 0, 0, d); check("R5 pot0 untouched", d, 0);
    endtask

    task automatic t_wiper();
        logic a; logic [5:0] w0;
        w0 = wiper_o[5:0];
        do_start();
        send_byte(ADDR_BYTE, a);
        send_byte(ins(4'hA, 0, 0), a);
        for (int i = 7; i >= 0; i--) send_bit(i == 4 || i == 0);
        send_bit(1'b0);
        check("R12 wiper held at write", wiper_o[5:0], w0);
        repeat (SET - 1) @(negedge clk);
        check("R12 wiper held SET", wiper_o[5:0], w0);
        repeat (3) @(negedge clk);
        check("R12 wiper settled", wiper_o[5:0], 6'h11);
        check("R12 other wiper", wiper_o[11:6], 6'h3F);
        do_stop();
    endtask

    task automatic t_dr_busy();
        logic [2:0] a; logic b; logic [7:0] d; logic ak; int cnt;
        wr3(4'hC, 2, 0, 8'h6A, a, b);
        check("R7 write dr acks", a, 3'b111);
        cnt = 0;
        while (busy_o && cnt < 4 * NV) begin cnt++; @(negedge clk); end
        check("R7 busy length", cnt, NV);
        wr3(4'hC, 1, 0, 8'h05, a, b);
        check("R7 busy after stop", b, 1);
        do_start(); send_byte(ADDR_BYTE, ak); do_stop();
        check("R3 no ack while busy", ak, 0);
        wait_idle();
        do_start(); send_byte(ADDR_BYTE, ak); do_stop();
        check("R3 ack after busy", ak, 1);
        rd3(4'hB, 2, 0, d); check("R7 read dr0_2", d, 8'h2A);
    endtask

    task automatic t_unknown();
        logic [2:0] a; logic b; logic [7:0] d;
        wr3(4'h3, 0, 0, 8'h07, a, b);
        check("R4 bad opcode acks", a, 3'b100);
        check("R4 bad opcode no busy", b, 0);
        wr3(4'hF, 0, 0, 8'h07, a, b);
        check("R4 opcode F acks", a, 3'b100);
        rd3(4'h9, 0, 0, d); check("R4 wcr0 unchanged", d, 8'h11);
    endtask

    task automatic t_transfers();
        logic [2:0] a; logic [1:0] a2; logic b; logic [7:0] d;
        wr3(4'hA, 0, 0, 8'h30, a, b);
        wr3(4'hA, 0, 1, 8'h22, a, b);
        xfer2(4'hD, 1, 0, a2, b);
        check("R8 acks", a2, 2'b11);
        check("R8 no busy", b, 0);
        rd3(4'h9, 0, 0, d); check("R8 wcr0", d, 8'h05);
        rd3(4'h9, 0, 1, d); check("R8 wcr1 kept", d, 8'h22);
        xfer2(4'hE, 3, 1, a2, b);
        check("R9 busy", b, 1);
        wait_idle();
        rd3(4'hB, 3, 1, d); check("R9 dr1_3", d, 8'h22);
        rd3(4'hB, 3, 0, d); check("R9 dr0_3 kept", d, 0);
        xfer2(4'h8, 0, 0, a2, b);
        check("R11 busy", b, 1);
        wait_idle();
        rd3(4'hB, 0, 0, d); check("R11 dr0_0", d, 8'h05);
        rd3(4'hB, 0, 1, d); check("R11 dr1_0", d, 8'h22);
        wr3(4'hA, 0, 0, 8'h01, a, b);
        wr3(4'hA, 0, 1, 8'h02, a, b);
        xfer2(4'h1, 0, 1, a2, b);
        check("R10 acks", a2, 2'b11);
        rd3(4'h9, 0, 0, d); check("R10 wcr0", d, 8'h05);
        rd3(4'h9, 0, 1, d); check("R10 wcr1", d, 8'h22);
    endtask

    task automatic t_restart();
        logic a; logic [7:0] d;
        do_start();
        send_byte(ADDR_BYTE, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        do_start();
        send_byte(ADDR_BYTE, a);
        check("R13 restart ack", a, 1);
        send_byte(ins(4'hA, 0, 0), a);
        send_byte(8'h19, a);
        check("R13 write after restart", a, 1);
        do_stop();
        for (int i = 7; i >= 0; i--) send_bit(ADDR_BYTE[i]);
        check("R13 no ack after stop", int'(ack_o), 0);
        send_bit(1'b0);
        rd3(4'h9, 0, 0, d); check("R13 wcr0", d, 8'h19);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_address();
        t_wcr();
        t_wiper();
        t_dr_busy();
        t_unknown();
        t_transfers();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule